// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Sequencer

This block keeps a fast page mode DRAM array alive. It first runs the power-up procedure. It waits for a long quiet interval and then runs a burst of column-before-row refresh cycles. After that it raises `init_done_o`. From then on an interval timer marks one refresh as owed each time the per-row share of the retention period elapses. The number of rows per retention period divided into the retention time gives that interval. Because the ordering is column-before-row, the DRAM's internal row counter supplies the refresh address, so the block drives no address at all.

When refreshes are owed and the block is idle, it raises `ref_req_o` towards the access controller. When `grant_i` is sampled high, the sequencer takes over the row strobe, column strobe and write enable. It then runs every owed refresh back to back. Refreshes that fall due while the grant is withheld are counted up to `MAX_PENDING`, and excess is dropped. `busy_o` covers the whole takeover, up to the end of the last precharge. An optional self-refresh mode is entered when `sref_i` and `grant_i` are both high while idle. The strobes are held low for at least the minimum self-refresh time and until `sref_i` drops. Leaving self refresh needs an exit precharge, and it clears the owed count and the interval timer. All times are given in nanoseconds and converted to clock cycles from `CLK_PERIOD_NS`.

Top module: `dram_refresh_seq`

## Requirements
- R1: During reset and right after it, `ras_n_o`, `cas_n_o` and `we_n_o` are 1, `busy_o`, `ref_req_o` and `init_done_o` are 0.
- R2: After reset the strobes stay high for the pause time (`INIT_PAUSE_NS` rounded up to cycles). Then `INIT_CYCLES` refresh cycles run back to back without any grant, and `init_done_o` rises after the last precharge and stays high.
- R3: In every refresh cycle the active-low column strobe falls a setup time (`T_CSR_NS`, at least one cycle) before the row strobe falls. It stays low for the whole row-strobe low time, and both strobes rise on the same edge.
- R4: The row strobe stays low for `T_RAS_NS` in cycles. The precharge that follows lasts at least `T_RP_NS` and long enough that falling edges of the row strobe are at least `T_RC_NS` apart.
- R5: `we_n_o` is 1 in every cycle, so no refresh cycle is ever taken as a write.
- R6: Once init is done, one refresh becomes owed every `RETENTION_US*1000/REFRESH_ROWS/CLK_PERIOD_NS` cycles. `ref_req_o` is 1 exactly when the block is idle and at least one refresh is owed.
- R7: The refresh takeover starts on the edge after `grant_i` is sampled high with `ref_req_o` high. A grant while nothing is owed (and `sref_i` low) has no effect on the strobes or `busy_o`.
- R8: Owed refreshes saturate at `MAX_PENDING`. One grant runs all owed refreshes back to back, including any that fall due during the burst.
- R9: `busy_o` is 1 from the edge after the grant until the last precharge ends. While it is 0 both strobes are high.
- R10: With `sref_i` and `grant_i` high while idle, the column strobe falls first. Then both strobes are low for at least `SREF_MIN_NS` and until `sref_i` is sampled low. A `T_RPS_NS` precharge with `busy_o` still high follows, after which no refresh is owed and the interval restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant_i | input | 1 | Access controller is idle and hands over the strobes |
| sref_i | input | 1 | Level request for self refresh |
| ref_req_o | output | 1 | Refresh owed and sequencer idle |
| busy_o | output | 1 | Sequencer owns the strobes |
| init_done_o | output | 1 | Power-up procedure complete |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |

## Verification
The hardest state to reach from the ports is a full owed count combined with timer ticks that land on the edge where a precharge ends. In that case the increment and the decrement cancel, and the burst must go on for one more cycle. The bench withholds the grant for more than `MAX_PENDING` intervals so the count saturates. It then grants once and counts the row-strobe falls in the burst. A long phase of sparse, irregular grants lets ticks drift across burst boundaries. Self refresh is driven with a release both shorter and longer than the minimum hold, so that both exit conditions are exercised.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE    = 3'd0,
        ST_IDLE     = 3'd1,
        ST_SETUP    = 3'd2,
        ST_ACTIVE   = 3'd3,
        ST_PRECH    = 3'd4,
        ST_SR_SETUP = 3'd5,
        ST_SR_HOLD  = 3'd6,
        ST_SR_EXIT  = 3'd7
    } seq_state_e;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
    parameter int LIMIT = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = $clog2(LIMIT < 2 ? 2 : LIMIT);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!en)       cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + TW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/refresh_debt_ctr.sv
module refresh_debt_ctr #(
    parameter int W        = 4,
    parameter int INIT_VAL = 8,
    parameter int MAX_VAL  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clr,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (load)
            cnt_d = W'(INIT_VAL);
        else if (dec && !inc)
            cnt_d = cnt_q - W'(1);
        else if (inc && !dec && (cnt_q < W'(MAX_VAL)))
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_refresh_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int REFRESH_ROWS  = 4096,
    parameter int RETENTION_US  = 64000,
    parameter int INIT_PAUSE_NS = 200000,
    parameter int INIT_CYCLES   = 8,
    parameter int MAX_PENDING   = 4,
    parameter int SREF_MIN_NS   = 100000,
    parameter int T_CSR_NS      = 10,
    parameter int T_RAS_NS      = 60,
    parameter int T_RP_NS       = 40,
    parameter int T_RC_NS       = 110,
    parameter int T_RPS_NS      = 110
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    input  logic sref_i,
    output logic ref_req_o,
    output logic busy_o,
    output logic init_done_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o
);
    localparam int CSR_CYC     = imax(1, cdiv(T_CSR_NS, CLK_PERIOD_NS));
    localparam int RAS_CYC     = imax(1, cdiv(T_RAS_NS, CLK_PERIOD_NS));
    localparam int RP_CYC      = imax(imax(1, cdiv(T_RP_NS, CLK_PERIOD_NS)),
                                      cdiv(T_RC_NS, CLK_PERIOD_NS) - RAS_CYC - CSR_CYC);
    localparam int REF_CYC     = imax(2, (RETENTION_US * 1000 / REFRESH_ROWS) / CLK_PERIOD_NS);
    localparam int PAUSE_CYC   = imax(1, cdiv(INIT_PAUSE_NS, CLK_PERIOD_NS));
    localparam int SR_MIN_CYC  = imax(1, cdiv(SREF_MIN_NS, CLK_PERIOD_NS));
    localparam int SR_EXIT_CYC = imax(1, cdiv(T_RPS_NS, CLK_PERIOD_NS));
    localparam int SEQ_MAX     = imax(imax(PAUSE_CYC, SR_MIN_CYC),
                                      imax(imax(CSR_CYC, RAS_CYC), imax(RP_CYC, SR_EXIT_CYC)));
    localparam int SEQ_W       = $clog2(SEQ_MAX + 1);
    localparam int DEBT_W      = $clog2(imax(INIT_CYCLES, MAX_PENDING) + 1);

    localparam logic [SEQ_W-1:0] PAUSE_LAST = SEQ_W'(PAUSE_CYC - 1);
    localparam logic [SEQ_W-1:0] CSR_LAST   = SEQ_W'(CSR_CYC - 1);
    localparam logic [SEQ_W-1:0] RAS_LAST   = SEQ_W'(RAS_CYC - 1);
    localparam logic [SEQ_W-1:0] RP_LAST    = SEQ_W'(RP_CYC - 1);
    localparam logic [SEQ_W-1:0] SRMIN_LAST = SEQ_W'(SR_MIN_CYC - 1);
    localparam logic [SEQ_W-1:0] SREX_LAST  = SEQ_W'(SR_EXIT_CYC - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [SEQ_W-1:0] seq;
        logic             init_done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              tick;
    logic              tmr_en;
    logic              debt_load, debt_clr, debt_dec;
    logic [DEBT_W-1:0] debt;
    logic              in_sr;

    assign in_sr  = (ctl_q.state == ST_SR_SETUP) || (ctl_q.state == ST_SR_HOLD) ||
                    (ctl_q.state == ST_SR_EXIT);
    assign tmr_en = ctl_q.init_done && !in_sr;

    refresh_interval_timer #(.LIMIT(REF_CYC)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (tmr_en),
        .tick  (tick)
    );

    refresh_debt_ctr #(
        .W        (DEBT_W),
        .INIT_VAL (INIT_CYCLES),
        .MAX_VAL  (MAX_PENDING)
    ) debt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (debt_load),
        .clr   (debt_clr),
        .inc   (tick),
        .dec   (debt_dec),
        .count (debt)
    );

    always_comb begin
        ctl_d     = ctl_q;
        debt_load = 1'b0;
        debt_clr  = 1'b0;
        debt_dec  = 1'b0;
        unique case (ctl_q.state)
            ST_PAUSE: begin
                if (ctl_q.seq == PAUSE_LAST) begin
                    ctl_d.state = ST_SETUP;
                    ctl_d.seq   = '0;
                    debt_load   = 1'b1;
                end else begin
                    ctl_d.seq = ctl_q.seq + SEQ_W'(1);
                end
            end
            ST_IDLE: begin
                ctl_d.seq = '0;
                if (grant_i && sref_i) begin
                    ctl_d.state = ST_SR_SETUP;
                    debt_clr    = 1'b1;
                end else if (grant_i && (debt != '0)) begin
                    ctl_d.state = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (ctl_q.seq == CSR_LAST) begin
                    ctl_d.state = ST_ACTIVE;
                    ctl_d.seq   = '0;
                end else begin
                    ctl_d.seq = ctl_q.seq + SEQ_W'(1);
                end
            end
            ST_ACTIVE: begin
                if (ctl_q.seq == RAS_LAST) begin
                    ctl_d.state = ST_PRECH;
                    ctl_d.seq   = '0;
                end else begin
                    ctl_d.seq = ctl_q.seq + SEQ_W'(1);
                end
            end
            ST_PRECH: begin
                if (ctl_q.seq == RP_LAST) begin
                    debt_dec  = 1'b1;
                    ctl_d.seq = '0;
                    if ((debt > DEBT_W'(1)) || tick) begin
                        ctl_d.state = ST_SETUP;
                    end else begin
                        ctl_d.state     = ST_IDLE;
                        ctl_d.init_done = 1'b1;
                    end
                end else begin
                    ctl_d.seq = ctl_q.seq + SEQ_W'(1);
                end
            end
            ST_SR_SETUP: begin
                if (ctl_q.seq == CSR_LAST) begin
                    ctl_d.state = ST_SR_HOLD;
                    ctl_d.seq   = '0;
                end else begin
                    ctl_d.seq = ctl_q.seq + SEQ_W'(1);
                end
            end
            ST_SR_HOLD: begin
                if (ctl_q.seq >= SRMIN_LAST) begin
                    if (!sref_i) begin
                        ctl_d.state = ST_SR_EXIT;
                        ctl_d.seq   = '0;
                    end
                end else begin
                    ctl_d.seq = ctl_q.seq + SEQ_W'(1);
                end
            end
            ST_SR_EXIT: begin
                if (ctl_q.seq == SREX_LAST) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.seq   = '0;
                end else begin
                    ctl_d.seq = ctl_q.seq + SEQ_W'(1);
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state     <= ST_PAUSE;
            ctl_q.seq       <= '0;
            ctl_q.init_done <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ras_n_o     = !((ctl_q.state == ST_ACTIVE) || (ctl_q.state == ST_SR_HOLD));
    assign cas_n_o     = !((ctl_q.state == ST_SETUP) || (ctl_q.state == ST_ACTIVE) ||
                           (ctl_q.state == ST_SR_SETUP) || (ctl_q.state == ST_SR_HOLD));
    assign we_n_o      = 1'b1;
    assign busy_o      = (ctl_q.state != ST_IDLE) && (ctl_q.state != ST_PAUSE);
    assign ref_req_o   = (ctl_q.state == ST_IDLE) && (debt != '0);
    assign init_done_o = ctl_q.init_done;

endmodule

// File: rtl/dram_refresh_seq_checker.sv
module dram_refresh_seq_checker #(
    parameter int RAS_CYC = 6,
    parameter int RP_CYC  = 4
) (
    input logic clk,
    input logic rst_n,
    input logic grant_i,
    input logic ref_req_o,
    input logic busy_o,
    input logic init_done_o,
    input logic ras_n_o,
    input logic cas_n_o
);
    logic [15:0] low_cnt, high_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            high_cnt <= '0;
        end else begin
            if (ras_n_o) begin
                low_cnt  <= '0;
                high_cnt <= (high_cnt == 16'hFFFF) ? high_cnt : high_cnt + 16'd1;
            end else begin
                high_cnt <= '0;
                low_cnt  <= (low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 16'd1;
            end
        end
    end

    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> $past(!cas_n_o)); // R3
    AST_CAS_COVERS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n_o |-> !cas_n_o); // R3
    AST_RAS_MIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> (low_cnt >= 16'(RAS_CYC))); // R4
    AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> (high_cnt >= 16'(RP_CYC))); // R4
    AST_REQ_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ref_req_o |-> (init_done_o && !busy_o)); // R6
    AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ras_n_o && cas_n_o)); // R9
    AST_START_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done_o && $rose(busy_o)) |-> $past(grant_i)); // R7
    AST_INIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(init_done_o) |-> init_done_o); // R2

endmodule

bind dram_refresh_seq dram_refresh_seq_checker #(
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .grant_i     (grant_i),
    .ref_req_o   (ref_req_o),
    .busy_o      (busy_o),
    .init_done_o (init_done_o),
    .ras_n_o     (ras_n_o),
    .cas_n_o     (cas_n_o)
);

// File: tb/dram_refresh_seq_tb_top.sv
module dram_refresh_seq_tb_top;
    localparam int CLK_NS  = 10;
    localparam int ROWS    = 32;
    localparam int RET_US  = 64;
    localparam int PAUSE_NS = 2000;
    localparam int N_INIT  = 8;
    localparam int MAXP    = 4;
    localparam int SRMIN_NS = 1000;

    // expected cycle counts, from the requirement formulas
    localparam int E_CSR   = 1;
    localparam int E_RAS   = 6;
    localparam int E_RP    = 4;
    localparam int E_REF   = (RET_US * 1000 / ROWS) / CLK_NS;   // 200
    localparam int E_PAUSE = PAUSE_NS / CLK_NS;                 // 200
    localparam int E_SRMIN = SRMIN_NS / CLK_NS;                 // 100
    localparam int E_SREX  = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant_i = 1'b0;
    logic sref_i = 1'b0;
    logic ref_req_o, busy_o, init_done_o, ras_n_o, cas_n_o, we_n_o;

    always #5 clk = ~clk;

    dram_refresh_seq #(
        .CLK_PERIOD_NS (CLK_NS),
        .REFRESH_ROWS  (ROWS),
        .RETENTION_US  (RET_US),
        .INIT_PAUSE_NS (PAUSE_NS),
        .INIT_CYCLES   (N_INIT),
        .MAX_PENDING   (MAXP),
        .SREF_MIN_NS   (SRMIN_NS)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_i     (grant_i),
        .sref_i      (sref_i),
        .ref_req_o   (ref_req_o),
        .busy_o      (busy_o),
        .init_done_o (init_done_o),
        .ras_n_o     (ras_n_o),
        .cas_n_o     (cas_n_o),
        .we_n_o      (we_n_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_ge(input string tag, input int act, input int lo);
        n_chk++;
        if (act < lo) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected>=%0d at %0t", tag, act, lo, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_ras[$];
    bit m_cas[$];
    bit m_last[$];
    int m_pause = 0;
    int m_tmr = 0;
    int m_pend = 0;
    int m_sr = 0;      // 0 none, 1 entry, 2 hold, 3 exit
    int m_src = 0;
    bit m_done = 1'b0;

    task automatic push_refresh();
        for (int i = 0; i < E_CSR; i++) begin m_ras.push_back(1); m_cas.push_back(0); m_last.push_back(0); end
        for (int i = 0; i < E_RAS; i++) begin m_ras.push_back(0); m_cas.push_back(0); m_last.push_back(0); end
        for (int i = 0; i < E_RP; i++) begin
            m_ras.push_back(1); m_cas.push_back(1); m_last.push_back(i == E_RP - 1);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ras.delete(); m_cas.delete(); m_last.delete();
            m_pause = 0; m_tmr = 0; m_pend = 0; m_sr = 0; m_src = 0; m_done = 0;
        end else begin
            bit tk;
            bit run;
            tk  = m_done && (m_sr == 0) && (m_tmr == E_REF - 1);
            run = m_done && (m_sr == 0);
            m_tmr = run ? (tk ? 0 : m_tmr + 1) : 0;
            if (m_ras.size() > 0) begin
                bit lst;
                void'(m_ras.pop_front()); void'(m_cas.pop_front());
                lst = m_last.pop_front();
                if (lst) begin
                    if (!tk) m_pend = m_pend - 1;
                    if (m_pend > 0) push_refresh();
                    else m_done = 1'b1;
                end else if (tk && m_pend < MAXP) m_pend++;
            end else if (m_sr == 1) begin
                m_src++;
                if (m_src == E_CSR) begin m_sr = 2; m_src = 0; end
            end else if (m_sr == 2) begin
                if (m_src >= E_SRMIN - 1 && !sref_i) begin m_sr = 3; m_src = 0; end
                else if (m_src < E_SRMIN - 1) m_src++;
            end else if (m_sr == 3) begin
                m_src++;
                if (m_src == E_SREX) m_sr = 0;
            end else if (!m_done) begin
                m_pause++;
                if (m_pause == E_PAUSE) begin m_pend = N_INIT; push_refresh(); end
            end else begin
                if (grant_i && sref_i) begin
                    m_pend = 0; m_sr = 1; m_src = 0;
                end else begin
                    bit start;
                    start = grant_i && (m_pend > 0);
                    if (tk && m_pend < MAXP) m_pend++;
                    if (start) push_refresh();
                end
            end
        end
    end

    // ---------------- per-cycle comparison and monitors ----------------
    int cyc = 0;
    int ras_falls = 0;
    int first_fall = -1;
    int low_run = 0;
    int last_low = 0;
    bit prev_ras = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            int e_ras, e_cas, e_busy, e_req;
            cyc++;
            if (m_ras.size() > 0) begin
                e_ras = m_ras[0]; e_cas = m_cas[0]; e_busy = 1;
            end else if (m_sr != 0) begin
                e_ras = (m_sr == 2) ? 0 : 1; e_cas = (m_sr == 3) ? 1 : 0; e_busy = 1;
            end else begin
                e_ras = 1; e_cas = 1; e_busy = 0;
            end
            e_req = (m_done && !e_busy && m_pend > 0) ? 1 : 0;
            check("R3 row strobe", int'(ras_n_o), e_ras);
            check("R4 column strobe", int'(cas_n_o), e_cas);
            check("R9 busy", int'(busy_o), e_busy);
            check("R6 request", int'(ref_req_o), e_req);
            check("R2 init done", int'(init_done_o), int'(m_done));
            check("R5 write enable high", int'(we_n_o), 1);
            if (prev_ras && !ras_n_o) begin
                ras_falls++;
                if (first_fall < 0) first_fall = cyc;
            end
            if (!ras_n_o) low_run++;
            else if (!prev_ras) begin last_low = low_run; low_run = 0; end
            prev_ras = ras_n_o;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        finish_run();
    end

    task automatic wait_idle();
        @(negedge clk);
        while (busy_o) @(negedge clk);
    endtask

    initial begin
        int f0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 ras_n in reset", int'(ras_n_o), 1);
        check("R1 cas_n in reset", int'(cas_n_o), 1);
        check("R1 we_n in reset", int'(we_n_o), 1);
        check("R1 busy in reset", int'(busy_o), 0);
        check("R1 req in reset", int'(ref_req_o), 0);
        check("R1 init_done in reset", int'(init_done_o), 0);
        rst_n = 1'b1;

        // R2: pause then init burst without any grant
        @(negedge clk);
        while (!init_done_o) @(negedge clk);
        check_ge("R2 pause length", first_fall, E_PAUSE + E_CSR);
        check("R2 init burst size", ras_falls, N_INIT);

        // R6/R7: grant when requested, with a lag
        for (int k = 0; k < 1500; k++) begin
            @(negedge clk);
            grant_i = ref_req_o && (k % 3 == 0);
        end
        @(negedge clk); grant_i = 1'b0;

        // R8: starve beyond the saturation limit, then one grant
        wait_idle();
        repeat ((MAXP + 2) * E_REF + 10) @(negedge clk);
        check("R8 request held while starved", int'(ref_req_o), 1);
        f0 = ras_falls;
        grant_i = 1'b1;
        @(negedge clk); grant_i = 1'b0;
        while (busy_o) @(negedge clk);
        check_ge("R8 saturated burst lower bound", ras_falls - f0, MAXP);
        check_ge("R8 saturated burst upper bound", MAXP + 1, ras_falls - f0);

        // R7: grant with nothing owed is ignored
        while (ref_req_o || busy_o) @(negedge clk);
        grant_i = 1'b1;
        @(negedge clk); grant_i = 1'b0;
        check("R7 no start without request busy", int'(busy_o), 0);
        check("R7 no start without request ras", int'(ras_n_o), 1);
        @(negedge clk);
        check("R7 no start without request cas", int'(cas_n_o), 1);

        // R10: short self-refresh request obeys the minimum hold
        wait_idle();
        sref_i = 1'b1; grant_i = 1'b1;
        @(negedge clk); grant_i = 1'b0;
        check("R10 entry busy", int'(busy_o), 1);
        check("R10 entry column first", int'(cas_n_o), 0);
        check("R10 entry row still high", int'(ras_n_o), 1);
        repeat (20) @(negedge clk);
        sref_i = 1'b0;
        while (busy_o) @(negedge clk);
        check("R10 minimum hold", last_low, E_SRMIN);
        repeat (E_REF - 5) begin
            @(negedge clk);
            check("R10 owed count cleared", int'(ref_req_o), 0);
        end

        // R10: long self-refresh request
        wait_idle();
        sref_i = 1'b1; grant_i = 1'b1;
        @(negedge clk); grant_i = 1'b0;
        repeat (300) @(negedge clk);
        sref_i = 1'b0;
        while (busy_o) @(negedge clk);
        check_ge("R10 hold follows request", last_low, 300);

        // mixed sparse grants: ticks drift across burst ends
        for (int k = 0; k < 2500; k++) begin
            @(negedge clk);
            grant_i = ((k * 7) % 11 == 0) || ((k % 97) == 5);
        end
        grant_i = 1'b0;
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule